// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is a register-mapped management master for the extended (Clause 45) register space of Ethernet PHYs. Software first loads a 16-bit register address. It then writes a command word that carries a 5-bit port address, a 5-bit device address and an operation code. Each accepted command becomes a pair of serial frames on the MDIO wire. The first frame is an address frame that sends the register address. The second is either a write frame that carries the command's data field or a read frame that captures 16 bits from the PHY.

The command word also serves as the status word. It reports whether a sequence is still running and whether read data is waiting, and its low half returns the captured data. A configuration register picks the MDC rate from four fixed ratios of the system clock. The MDIO pin is presented as a tri-state triple: output value, output enable and input value. The register interface has no back-pressure: writes take effect in the cycle they are presented, and reads are combinational.

Top module: `c45_mdio_master`

## Requirements
- R1: The command/status word is at offset 0x0, the register-address word at offset 0x8 and the configuration word at offset 0xC. The register-address word keeps bits 15:0 of a write and reads zero above them. The configuration word reads back all 32 bits last written. All three read zero after reset.
- R2: A write to offset 0x0 starts a sequence only when bits 28:26 hold 5 (write) or 7 (read) and no sequence is running. Any other code starts nothing, produces no MDC activity and leaves the status word unchanged.
- R3: The first frame of every sequence is sent MSB first and is 64 bits long. It consists of 32 preamble ones, start code 00, opcode 00, the port address (command bits 20:16), the device address (command bits 25:21), turnaround 10, and then the 16-bit register address. The pin is driven for the whole frame.
- R4: For a write, the second frame uses opcode 01 and carries command bits 15:0, with the pin driven throughout. For a read, it uses opcode 11, and the output enable drops from the first turnaround bit to the end of the frame.
- R5: Status bit 30 (busy) is set from the cycle after an accepted command and stays set until the second frame has completed. It then clears.
- R6: In a read frame, the 16 data bits are sampled on MDC rising edges. After the read completes, status bits 15:0 return them and bit 29 (read valid) is set. An accepted new command clears bit 29.
- R7: Configuration bits 1:0 set the MDC period in system clocks: 0 gives 256, 1 gives 64, 2 gives 32 and 3 gives 8. MDC is high for half the period and low for the other half.
- R8: A divider change takes effect at the start of the next frame, never inside a running frame. This includes a change made between the two frames of one sequence.
- R9: A write to offset 0x0 while busy is ignored. The running frames and the latched port, device and opcode fields are unaffected, and no extra frame follows.
- R10: MDIO output and enable change only in the cycle where MDC falls, or when a frame starts. When idle, MDC is low and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | REG_AW | Register write byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | REG_AW | Register read byte offset |
| reg_rdata | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The hardest situation to reach from the ports is a divider change that arrives between the two frames of one sequence. A frame must keep its old rate, and the next frame must pick up the new one. The bench starts a sequence at the fastest ratio and rewrites the configuration word partway through the address frame. It then measures every MDC high phase of each frame separately at the pin. A write-while-busy lands in the middle of a running address frame; the bench then confirms the data frame and the status fields still belong to the first command. The bench also sweeps all 32 port addresses, alternating reads and writes. During read frames, a behavioural PHY model drives known data onto the input pin.

// File: rtl/c45_mdio_pkg.sv
package c45_mdio_pkg;

  localparam int OFS_MGMT = 'h0;
  localparam int OFS_ADDR = 'h8;
  localparam int OFS_CFG  = 'hC;

  localparam logic [2:0] CMD_WRITE = 3'd5;
  localparam logic [2:0] CMD_READ  = 3'd7;

  localparam logic [1:0] FOP_ADDR  = 2'b00;
  localparam logic [1:0] FOP_WRITE = 2'b01;
  localparam logic [1:0] FOP_READ  = 2'b11;
  localparam logic [1:0] FST_C45   = 2'b00;
  localparam logic [1:0] FTA_DRIVE = 2'b10;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ADDR, SQ_DATA} seq_state_t;

  // Half of the MDC period in system clocks for a divider code.
  function automatic logic [7:0] half_period(input logic [1:0] sel);
    case (sel)
      2'd0:    half_period = 8'd128;
      2'd1:    half_period = 8'd32;
      2'd2:    half_period = 8'd16;
      default: half_period = 8'd4;
    endcase
  endfunction

endpackage

// File: rtl/c45_mdio_clkgen.sv
module c45_mdio_clkgen
  import c45_mdio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       mdc,
  output logic       rise_tick,
  output logic       bit_tick
);
  localparam int CNT_W = 8;

  logic [CNT_W-1:0] half_q;
  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;
  logic             tick;

  assign tick      = run && (cnt_q == half_q - 8'd1);
  assign mdc       = phase_q;
  assign rise_tick = tick && !phase_q;
  assign bit_tick  = tick && phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q  <= half_period(2'd0);
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      if (load) half_q <= half_period(sel);
      if (load || !run) begin
        cnt_q   <= '0;
        phase_q <= 1'b0;
      end else if (tick) begin
        cnt_q   <= '0;
        phase_q <= !phase_q;
      end else begin
        cnt_q <= cnt_q + 8'd1;
      end
    end
  end

  logic [CNT_W:0] hi_len_q;
  always_ff @(posedge clk) begin
    if (!rst_n) hi_len_q <= '0;
    else        hi_len_q <= mdc ? hi_len_q + 9'd1 : '0;
  end

  // R7
  mdc_high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc) |-> hi_len_q == {1'b0, half_q});

  // R10
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);

endmodule

// File: rtl/c45_mdio_shifter.sv
module c45_mdio_shifter #(
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] body,
  input  logic        rd_frame,
  input  logic        rise_tick,
  input  logic        bit_tick,
  input  logic        mdio_i,
  output logic        active,
  output logic        done,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [15:0] rdata
);
  localparam int FRAME_BITS = PRE_LEN + 32;
  localparam int IDX_W      = $clog2(FRAME_BITS + 1);
  localparam logic [IDX_W-1:0] IDX_BODY = IDX_W'(PRE_LEN);
  localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(PRE_LEN + 14);
  localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(PRE_LEN + 16);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);

  logic [IDX_W-1:0] idx_q;
  logic [31:0]      body_q;
  logic             rd_q;
  logic             active_q;

  assign active  = active_q;
  assign done    = active_q && bit_tick && (idx_q == IDX_LAST);
  assign mdio_o  = (!active_q || idx_q < IDX_BODY) ? 1'b1 : body_q[31];
  assign mdio_oe = active_q && !(rd_q && idx_q >= IDX_TA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q    <= '0;
      body_q   <= '0;
      rd_q     <= 1'b0;
      active_q <= 1'b0;
      rdata    <= '0;
    end else if (load) begin
      idx_q    <= '0;
      body_q   <= body;
      rd_q     <= rd_frame;
      active_q <= 1'b1;
      rdata    <= '0;
    end else if (active_q) begin
      if (rise_tick && rd_q && idx_q >= IDX_DATA)
        rdata <= {rdata[14:0], mdio_i};
      if (bit_tick) begin
        if (idx_q == IDX_LAST) begin
          active_q <= 1'b0;
        end else begin
          idx_q <= idx_q + 1'b1;
          if (idx_q >= IDX_BODY) body_q <= {body_q[30:0], 1'b0};
        end
      end
    end
  end

  // R10
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !mdio_oe || load);

endmodule

// File: rtl/c45_mdio_seq.sv
module c45_mdio_seq
  import c45_mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [15:0] cmd_data,
  input  logic [4:0]  cmd_prt,
  input  logic [4:0]  cmd_dev,
  input  logic [2:0]  cmd_op,
  input  logic [15:0] reg_addr,
  input  logic        frame_done,
  input  logic [15:0] cap_data,
  output logic        busy,
  output logic        valid,
  output logic        load,
  output logic [31:0] body,
  output logic        rd_frame,
  output logic [15:0] data_q,
  output logic [4:0]  prt_q,
  output logic [4:0]  dev_q,
  output logic [2:0]  op_q
);
  seq_state_t state_q;
  logic       accept;
  logic       is_rd;

  assign accept = cmd_wr && (state_q == SQ_IDLE) &&
                  (cmd_op == CMD_WRITE || cmd_op == CMD_READ);
  assign is_rd  = (op_q == CMD_READ);
  assign busy   = (state_q != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      valid    <= 1'b0;
      load     <= 1'b0;
      body     <= '0;
      rd_frame <= 1'b0;
      data_q   <= '0;
      prt_q    <= '0;
      dev_q    <= '0;
      op_q     <= '0;
    end else begin
      load <= 1'b0;
      case (state_q)
        SQ_IDLE: if (accept) begin
          prt_q    <= cmd_prt;
          dev_q    <= cmd_dev;
          op_q     <= cmd_op;
          data_q   <= cmd_data;
          valid    <= 1'b0;
          load     <= 1'b1;
          rd_frame <= 1'b0;
          body     <= {FST_C45, FOP_ADDR, cmd_prt, cmd_dev, FTA_DRIVE, reg_addr};
          state_q  <= SQ_ADDR;
        end
        SQ_ADDR: if (frame_done) begin
          load     <= 1'b1;
          rd_frame <= is_rd;
          body     <= {FST_C45, is_rd ? FOP_READ : FOP_WRITE, prt_q, dev_q,
                       FTA_DRIVE, is_rd ? 16'h0000 : data_q};
          state_q  <= SQ_DATA;
        end
        SQ_DATA: if (frame_done) begin
          state_q <= SQ_IDLE;
          if (is_rd) begin
            valid  <= 1'b1;
            data_q <= cap_data;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_wr |=> $stable(prt_q) && $stable(dev_q) && $stable(op_q));

  // R6
  valid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !valid);

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_DATA) && !frame_done |=> busy);

endmodule

// File: rtl/c45_mdio_master.sv
module c45_mdio_master
  import c45_mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int REG_AW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_waddr,
  input  logic [31:0]       reg_wdata,
  input  logic [REG_AW-1:0] reg_raddr,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam logic [REG_AW-1:0] A_MGMT = REG_AW'(OFS_MGMT);
  localparam logic [REG_AW-1:0] A_ADDR = REG_AW'(OFS_ADDR);
  localparam logic [REG_AW-1:0] A_CFG  = REG_AW'(OFS_CFG);

  logic [31:0] cfg_q;
  logic [15:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      addr_q <= '0;
    end else if (reg_wr) begin
      if (reg_waddr == A_CFG)  cfg_q  <= reg_wdata;
      if (reg_waddr == A_ADDR) addr_q <= reg_wdata[15:0];
    end
  end

  logic        busy, valid, load, rd_frame, active, done;
  logic        rise_tick, bit_tick;
  logic [31:0] body;
  logic [15:0] data_q, cap_data;
  logic [4:0]  prt_q, dev_q;
  logic [2:0]  op_q;

  c45_mdio_seq seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (reg_wr && reg_waddr == A_MGMT),
    .cmd_data   (reg_wdata[15:0]),
    .cmd_prt    (reg_wdata[20:16]),
    .cmd_dev    (reg_wdata[25:21]),
    .cmd_op     (reg_wdata[28:26]),
    .reg_addr   (addr_q),
    .frame_done (done),
    .cap_data   (cap_data),
    .busy       (busy),
    .valid      (valid),
    .load       (load),
    .body       (body),
    .rd_frame   (rd_frame),
    .data_q     (data_q),
    .prt_q      (prt_q),
    .dev_q      (dev_q),
    .op_q       (op_q)
  );

  c45_mdio_clkgen clkgen_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .run       (active),
    .sel       (cfg_q[1:0]),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .bit_tick  (bit_tick)
  );

  c45_mdio_shifter #(.PRE_LEN(PRE_LEN)) shifter_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .body      (body),
    .rd_frame  (rd_frame),
    .rise_tick (rise_tick),
    .bit_tick  (bit_tick),
    .mdio_i    (mdio_i),
    .active    (active),
    .done      (done),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .rdata     (cap_data)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_raddr == A_MGMT)
      reg_rdata = {1'b0, busy, valid, op_q, dev_q, prt_q, data_q};
    else if (reg_raddr == A_ADDR)
      reg_rdata = {16'h0000, addr_q};
    else if (reg_raddr == A_CFG)
      reg_rdata = cfg_q;
  end

  // R10
  pin_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdc && $past(mdc) |-> $stable(mdio_o) && $stable(mdio_oe));

endmodule

// File: tb/c45_mdio_master_tb_top.sv
module c45_mdio_master_tb_top;
  localparam int PRE = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  c45_mdio_master #(.PRE_LEN(PRE), .REG_AW(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // Pin monitor and PHY model
  logic         mon_clr = 1'b0;
  logic [15:0]  phy_pat = '0;
  logic [127:0] go, goe;
  int rc = 0, hrun = 0;
  int hmin[2], hmax[2];
  logic pmdc = 1'b0;

  always @(negedge clk) begin
    if (mon_clr) begin
      rc = 0; hrun = 0;
      hmin[0] = 9999; hmin[1] = 9999; hmax[0] = 0; hmax[1] = 0;
      go = '0; goe = '0;
    end else begin
      if (mdc) hrun++;
      if (mdc && !pmdc) begin
        if (rc < 128) begin go[rc] = mdio_o; goe[rc] = mdio_oe; end
        rc++;
      end
      if (!mdc && pmdc) begin
        int f;
        f = (rc > 64) ? 1 : 0;
        if (hrun < hmin[f]) hmin[f] = hrun;
        if (hrun > hmax[f]) hmax[f] = hrun;
        hrun = 0;
      end
    end
    pmdc = mdc;
  end

  always_comb begin
    int j;
    j = rc - 64 - PRE - 16;
    mdio_i = (j >= 0 && j < 16) ? phy_pat[15 - j] : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_raddr = a; #0.1; d = reg_rdata;
  endtask

  function automatic int half_of(input int sel);
    case (sel) 0: return 128; 1: return 32; 2: return 16; default: return 4; endcase
  endfunction

  task automatic clear_mon();
    @(posedge clk); mon_clr = 1'b1;
    @(posedge clk); mon_clr = 1'b0;
  endtask

  task automatic wait_idle(output bit ok);
    logic [31:0] v;
    ok = 1'b0;
    for (int n = 0; n < 40000; n++) begin
      @(negedge clk); rd(4'h0, v);
      if (!v[30]) begin ok = 1'b1; break; end
    end
  endtask

  // Full sequence with optional mid-flight disturbance
  task automatic run_op(input logic [4:0] prt, input logic [4:0] dev,
                        input logic [15:0] ra, input bit is_rd,
                        input logic [15:0] wd, input logic [15:0] pat,
                        input int sel1, input int sel2,
                        input bit junk, input bit cfg_mid);
    logic [31:0] v;
    logic [63:0] e1, e2;
    logic [1:0]  fop;
    bit ok, m1, m2;
    phy_pat = pat;
    wr(4'h8, {16'hFFFF, ra});
    clear_mon();
    wr(4'h0, {3'b000, is_rd ? 3'd7 : 3'd5, dev, prt, wd});
    rd(4'h0, v);
    chk(v[30] == 1'b1, "R5 busy after start", v[30], 1);
    if (junk) begin
      repeat (50) @(negedge clk);
      wr(4'h0, {3'b000, 3'd7, ~dev, ~prt, ~wd});
    end
    if (cfg_mid) begin
      repeat (100) @(negedge clk);
      wr(4'hC, sel2);
    end
    wait_idle(ok);
    chk(ok, "R5 busy clears", ok, 1);
    repeat (20) @(negedge clk);
    chk(rc == 128, "R9 two frames only", rc, 128);
    e1 = {32'hFFFF_FFFF, 2'b00, 2'b00, prt, dev, 2'b10, ra};
    fop = is_rd ? 2'b11 : 2'b01;
    e2 = {32'hFFFF_FFFF, 2'b00, fop, prt, dev, 2'b10, wd};
    m1 = 1'b0; m2 = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (go[i] !== e1[63-i] || goe[i] !== 1'b1) m1 = 1'b1;
      if (!is_rd || i < PRE + 14) begin
        if (go[64+i] !== e2[63-i] || goe[64+i] !== 1'b1) m2 = 1'b1;
      end else if (goe[64+i] !== 1'b0) m2 = 1'b1;
    end
    chk(!m1, "R3 address frame", {prt, dev, ra}, {prt, dev, ra});
    chk(!m2, is_rd ? "R4 read frame" : "R4 write frame", fop, fop);
    chk(hmin[0] == half_of(sel1) && hmax[0] == half_of(sel1),
        "R7 R8 frame1 MDC half", hmax[0], half_of(sel1));
    chk(hmin[1] == half_of(sel2) && hmax[1] == half_of(sel2),
        "R7 R8 frame2 MDC half", hmax[1], half_of(sel2));
    rd(4'h0, v);
    chk(v[25:16] == {dev, prt} && v[28:26] == (is_rd ? 3'd7 : 3'd5),
        "R9 latched fields", v[28:16], {is_rd ? 3'd7 : 3'd5, dev, prt});
    if (is_rd)
      chk(v[29] && v[15:0] == pat, "R6 read data valid", v[29:0], {1'b1, 13'h0, pat});
    else
      chk(!v[29] && v[15:0] == wd, "R6 write no valid", v[29:0], wd);
  endtask

  initial begin
    int wd_cnt = 0;
    forever begin
      @(posedge clk); wd_cnt++;
      if (wd_cnt > 190000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=done", wd_cnt);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R10 idle pins
    rd(4'h0, v); chk(v == 0, "R1 reset mgmt", v, 0);
    rd(4'hC, v); chk(v == 0, "R1 reset cfg", v, 0);
    chk(mdc == 0 && mdio_oe == 0, "R10 idle pins", {mdc, mdio_oe}, 0);
    // R1 readback
    wr(4'hC, 32'hA5A5_5A5F);
    rd(4'hC, v); chk(v == 32'hA5A5_5A5F, "R1 cfg readback", v, 32'hA5A5_5A5F);
    wr(4'h8, 32'h1234_BEEF);
    rd(4'h8, v); chk(v == 32'h0000_BEEF, "R1 addr readback", v, 32'h0000_BEEF);
    // R2 invalid opcode ignored
    clear_mon();
    wr(4'h0, {3'b000, 3'd3, 5'd9, 5'd4, 16'h1111});
    rd(4'h0, v); chk(v == 0, "R2 bad op ignored", v, 0);
    repeat (300) @(negedge clk);
    chk(rc == 0 && mdc == 0, "R2 no MDC on bad op", rc, 0);
    // Sweep all port addresses at the fastest ratio
    wr(4'hC, 32'h3);
    for (int p = 0; p < 32; p++) begin
      logic [15:0] ra;
      ra = 16'(p * 16'h0813) ^ 16'hA5C3;
      run_op(5'(p), 5'((p * 7 + 3) % 32), ra, p[0], ~ra,
             {4'(p), 4'(~p), 4'(p + 5), 4'(p * 3)}, 3, 3, 1'b0, 1'b0);
    end
    // R6 valid cleared by new command (last sweep op was a read)
    wr(4'h8, 32'h0);
    wr(4'h0, {3'b000, 3'd5, 5'd1, 5'd1, 16'h0});
    rd(4'h0, v); chk(!v[29], "R6 valid cleared", v[29], 0);
    begin bit ok; wait_idle(ok); end
    // R7 each slower ratio
    for (int s = 0; s < 3; s++) begin
      wr(4'hC, s);
      run_op(5'd17, 5'd30, 16'h8001, s[0], 16'h7E81, 16'hC3A5, s, s, 1'b0, 1'b0);
    end
    // R8 divider change between frames of one sequence
    wr(4'hC, 32'h3);
    run_op(5'd6, 5'd2, 16'h0F0F, 1'b1, 16'h0, 16'h5AA5, 3, 2, 1'b0, 1'b1);
    // R9 write while busy ignored
    wr(4'hC, 32'h3);
    run_op(5'd5, 5'd10, 16'h1357, 1'b0, 16'hBEEF, 16'h0, 3, 3, 1'b1, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule